// File: doc/BRIEF.md
# Multi-Target Sync Pulse Router

This block routes one-cycle synchronization pulses to five transmit-path sub-blocks. Target 0 is the complex mixer, 1 the FIFO, 2 the clock divider, 3 the quadrature offset correction and 4 the quadrature gain/phase correction. A sync event comes from one of two places: a rising edge on the sync pin, which arrives already synchronous to the clock, or a 0-to-1 change of a trigger bit that software writes.

Software controls the routing through three byte-wide registers on a simple write port.

- **Global mode.** One source bit steers all five targets together.
- **Per-target mode.** Each target picks its own source, or is switched off, through its own bits.

All registers can be read back.

Register map:

- **Address 0, mode register.** Bits [4:0] hold the per-target source bits, where 1 means software trigger. Bit 5 is the global source bit, where 1 means software trigger. Bit 6 selects per-target mode when 1 and global mode when 0.
- **Address 1, trigger register.** Bits [4:0] are the per-target trigger bits. Bit 5 is the global trigger bit.
- **Address 2, mask register.** Bits [4:0] are the per-target disable bits.
- **Address 3** is not mapped.

Top module: `sync_router`

## Requirements
- R1: After reset all three registers read 0x00, all outputs are low, and every target takes its events from the sync pin.
- R2: In global mode with the global source bit at 0, a rising edge of the sync pin makes all five outputs pulse together.
- R3: In global mode with the global source bit at 1, only a 0-to-1 write of trigger bit 5 pulses all five outputs. In that setting the pin has no effect.
- R4: In per-target mode, target i pulses on a pin rising edge when mode bit i is 0, and on a 0-to-1 write of trigger bit i when mode bit i is 1.
- R5: In per-target mode, a target whose mask bit is 1 keeps its output low whatever the pin or the trigger bits do.
- R6: The per-target trigger bits have no effect in global mode. The global trigger bit has no effect in per-target mode.
- R7: Writing 1 over a trigger bit that already holds 1 produces no pulse. The bit must be written to 0 first before it can trigger again.
- R8: Each qualifying edge gives exactly one pulse, one clock wide, registered in the clock edge where the edge is seen or the write occurs. A pin held high gives only one pulse.
- R9: Each mapped register stores and reads back the full written byte. Address 3 reads 0x00 and ignores writes.
- R10: A write to the mode or mask register affects routing only from the next clock onward. An event seen in the same edge as that write follows the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pin | input | 1 | Synchronous sync level from the pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Read data for rd_addr, combinational |
| sync_out | output | 5 | One-cycle sync pulses, bit i drives target i |

## Verification
The bench compares every output bit each cycle against a behavioural model. It looks for the following faults.

- **Repeated pin pulses.** A pin held high for several cycles must give one pulse. A level-sensitive design would give a pulse train.
- **Rewriting a trigger bit.** Writing 1 over a stored 1 must stay silent. Edge detection against the bus data alone would pulse again.
- **Cross-mode triggers.** Each trigger bit must stay silent in the mode it does not belong to. A design that ORs all triggers together would leak pulses across modes.
- **Masked targets.** A masked target must stay low while its neighbours pulse.
- **Same-cycle mode change.** A mode write in the same cycle as a pin edge must route by the old mode. A design with an off-by-one in config timing would pulse on the wrong set of targets.

// File: rtl/sync_router_pkg.sv
// Package: shared constants for the sync pulse router.
// Assumes five targets and byte-wide registers, so the two global bits
// fit above the per-target bits in the mode register.
package sync_router_pkg;
    localparam int unsigned NUM_TARGETS = 5;
    localparam int unsigned REG_W       = 8;
    localparam int unsigned ADDR_W      = 2;

    // Register addresses: the trigger register follows the mode register.
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_TRIG = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd2;

    // Bit positions of the global fields, placed just above the per-target bits.
    localparam int unsigned GLOB_SRC_BIT  = NUM_TARGETS;
    localparam int unsigned PER_TGT_BIT   = NUM_TARGETS + 1;
    localparam int unsigned GLOB_TRIG_BIT = NUM_TARGETS;
endpackage

// File: rtl/sync_pin_edge.sv
// Module: sync_pin_edge
// Turns the sync pin level into a single-cycle rising-edge flag.
// Assumes the pin is already synchronous to clk; no synchronizer is used.
module sync_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pin,
    output logic pin_rise
);
    logic pin_q;

    // Purpose: remember the pin level from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= sync_pin;
    end

    assign pin_rise = sync_pin & ~pin_q;

    // A held pin cannot flag two edges in a row.
    assert_pin_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);
endmodule

// File: rtl/sync_reg_bank.sv
// Module: sync_reg_bank
// Holds the mode, trigger and mask registers, gives combinational readback,
// and flags 0-to-1 trigger-bit writes by comparing new data with stored data.
// Assumes one write per clock; unmapped addresses ignore writes and read zero.
module sync_reg_bank
    import sync_router_pkg::*;
#(
    parameter int unsigned N_TGT = NUM_TARGETS,
    parameter int unsigned DW    = REG_W,
    parameter int unsigned AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             per_target,
    output logic             glob_sw,
    output logic [N_TGT-1:0] tgt_sw,
    output logic [N_TGT-1:0] tgt_off,
    output logic [N_TGT-1:0] soft_tgt,
    output logic             soft_glob
);
    localparam int unsigned TRIG_BITS = N_TGT + 1;

    logic [DW-1:0] mode_q, trig_q, mask_q;
    logic          trig_wr;
    logic [TRIG_BITS-1:0] trig_rise;

    // Purpose: capture register writes by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            trig_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_MODE) mode_q <= wr_data;
            if (wr_addr == ADDR_TRIG) trig_q <= wr_data;
            if (wr_addr == ADDR_MASK) mask_q <= wr_data;
        end
    end

    // Purpose: select readback data for the requested address.
    always_comb begin
        case (rd_addr)
            ADDR_MODE: rd_data = mode_q;
            ADDR_TRIG: rd_data = trig_q;
            ADDR_MASK: rd_data = mask_q;
            default:   rd_data = '0;
        endcase
    end

    assign trig_wr   = wr_en && (wr_addr == ADDR_TRIG);
    assign trig_rise = trig_wr ? (wr_data[TRIG_BITS-1:0] & ~trig_q[TRIG_BITS-1:0])
                               : '0;

    assign soft_tgt   = trig_rise[N_TGT-1:0];
    assign soft_glob  = trig_rise[GLOB_TRIG_BIT];
    assign per_target = mode_q[PER_TGT_BIT];
    assign glob_sw    = mode_q[GLOB_SRC_BIT];
    assign tgt_sw     = mode_q[N_TGT-1:0];
    assign tgt_off    = mask_q[N_TGT-1:0];

    // A flagged trigger edge leaves the bit set, so a rewrite of 1 cannot re-fire.
    assert_rise_sets_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_glob |=> trig_q[GLOB_TRIG_BIT]);
    // A write to the unmapped address leaves every register unchanged.
    assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=>
            ($stable(mode_q) && $stable(trig_q) && $stable(mask_q)));
endmodule

// File: rtl/sync_target_sel.sv
// Module: sync_target_sel
// Chooses the event for each target from the pin edge or the software
// triggers according to the mode and mask fields, and registers the pulses.
// Assumes its event inputs are single-cycle flags.
module sync_target_sel #(
    parameter int unsigned N_TGT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_target,
    input  logic             glob_sw,
    input  logic [N_TGT-1:0] tgt_sw,
    input  logic [N_TGT-1:0] tgt_off,
    input  logic             pin_rise,
    input  logic             soft_glob,
    input  logic [N_TGT-1:0] soft_tgt,
    output logic [N_TGT-1:0] sync_out
);
    logic [N_TGT-1:0] ev;
    logic             glob_ev;

    assign glob_ev = glob_sw ? soft_glob : pin_rise;

    for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
        assign ev[i] = !per_target ? glob_ev :
                       tgt_off[i]  ? 1'b0    :
                       tgt_sw[i]   ? soft_tgt[i] : pin_rise;

        // A masked target in per-target mode stays silent next cycle.
        assert_masked_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (per_target && tgt_off[i]) |=> !sync_out[i]);
        // Every pulse traces back to an event flag one cycle earlier.
        assert_pulse_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            sync_out[i] |-> $past(pin_rise || soft_glob || soft_tgt[i]));
    end

    // Purpose: register the selected events as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_out <= '0;
        else        sync_out <= ev;
    end

    // In global mode all targets move together.
    assert_global_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !per_target |=> (sync_out == '0 || sync_out == '1));
endmodule

// File: rtl/sync_router.sv
// Module: sync_router (top)
// Routes sync pulses from the pin or from software trigger bits to five
// transmit-path targets. Assumes sync_pin is synchronous to clk.
module sync_router
    import sync_router_pkg::*;
#(
    parameter int unsigned N_TGT = NUM_TARGETS,
    parameter int unsigned DW    = REG_W,
    parameter int unsigned AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pin,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [N_TGT-1:0] sync_out
);
    logic             pin_rise, per_target, glob_sw, soft_glob;
    logic [N_TGT-1:0] tgt_sw, tgt_off, soft_tgt;

    sync_pin_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_pin (sync_pin),
        .pin_rise (pin_rise)
    );

    sync_reg_bank #(.N_TGT(N_TGT), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .per_target (per_target),
        .glob_sw    (glob_sw),
        .tgt_sw     (tgt_sw),
        .tgt_off    (tgt_off),
        .soft_tgt   (soft_tgt),
        .soft_glob  (soft_glob)
    );

    sync_target_sel #(.N_TGT(N_TGT)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_target (per_target),
        .glob_sw    (glob_sw),
        .tgt_sw     (tgt_sw),
        .tgt_off    (tgt_off),
        .pin_rise   (pin_rise),
        .soft_glob  (soft_glob),
        .soft_tgt   (soft_tgt),
        .sync_out   (sync_out)
    );
endmodule

// File: tb/sync_router_tb_top.sv
// Bench: behavioural reference model compared with the outputs every clock.
module sync_router_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic [4:0] sync_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string phase = "R1";

    // Reference model state.
    logic [7:0] m_reg [4];
    bit         m_pin;
    logic [4:0] exp_out;
    bit         m_prise;
    logic [5:0] m_srise;

    always #2.5 clk = ~clk;

    sync_router dut_i (
        .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sync_out(sync_out)
    );

    // Model: events seen at an edge become pulses right after that edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            foreach (m_reg[k]) m_reg[k] = 8'h00;
            m_pin   = 1'b0;
            exp_out = 5'b0;
        end else begin
            m_prise = sync_pin && !m_pin;
            m_srise = (wr_en && wr_addr == 2'd1) ? (wr_data[5:0] & ~m_reg[1][5:0]) : 6'b0;
            for (int i = 0; i < 5; i++) begin
                if (!m_reg[0][6])     exp_out[i] = m_reg[0][5] ? m_srise[5] : m_prise;
                else if (m_reg[2][i]) exp_out[i] = 1'b0;
                else                  exp_out[i] = m_reg[0][i] ? m_srise[i] : m_prise;
            end
            if (wr_en && wr_addr != 2'd3) m_reg[wr_addr] = wr_data;
            m_pin = sync_pin;
        end
    end

    // Compare outputs each cycle, away from the active edge.
    always @(negedge clk) begin
        if (cyc > 1) begin
            checks++;
            if (sync_out !== exp_out) begin
                fails++;
                $display("FAIL %s: sync_out actual %b expected %b at cycle %0d",
                         phase, sync_out, exp_out, cyc);
            end
        end
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected under 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pin_pulse(input int hold);
        @(negedge clk);
        sync_pin = 1'b1;
        repeat (hold) @(negedge clk);
        sync_pin = 1'b0;
        idle(2);
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data[%0d] actual %h expected %h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset values, pin is source.
        phase = "R1";
        rd_check(2'd0, 8'h00, "R1");
        rd_check(2'd1, 8'h00, "R1");
        rd_check(2'd2, 8'h00, "R1");
        // R2 and R8: global pin mode, held pin gives one pulse.
        phase = "R2/R8";
        pin_pulse(1);
        pin_pulse(4);
        // R3: global software source; pin ignored.
        phase = "R3";
        wr(2'd0, 8'h20);
        wr(2'd1, 8'h20);
        idle(1);
        pin_pulse(2);
        // R7: rewrite of 1 is silent, clear and set re-triggers.
        phase = "R7";
        wr(2'd1, 8'h20);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h20);
        // R6: per-target triggers ignored in global mode.
        phase = "R6";
        wr(2'd1, 8'h1F);
        wr(2'd1, 8'h00);
        // R4: per-target mode, targets 0 and 2 software, others pin.
        phase = "R4";
        wr(2'd0, 8'h45);
        pin_pulse(1);
        wr(2'd1, 8'h1F);
        wr(2'd1, 8'h00);
        // R6: global trigger ignored in per-target mode.
        phase = "R6";
        wr(2'd1, 8'h20);
        wr(2'd1, 8'h00);
        // R5: mask targets 0 and 3.
        phase = "R5";
        wr(2'd2, 8'h09);
        pin_pulse(1);
        wr(2'd1, 8'h1F);
        wr(2'd1, 8'h00);
        // R10: mode write and pin edge at the same edge follow old settings.
        phase = "R10";
        @(negedge clk);
        sync_pin = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0; sync_pin = 1'b0;
        idle(2);
        pin_pulse(1);
        // R9: full-byte storage and unmapped address.
        phase = "R9";
        wr(2'd2, 8'hC0);
        rd_check(2'd2, 8'hC0, "R9");
        wr(2'd3, 8'h7F);
        rd_check(2'd3, 8'h00, "R9");
        rd_check(2'd0, 8'h00, "R9");
        rd_check(2'd1, 8'h00, "R9");
        pin_pulse(1);
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule